// File: doc/BRIEF.md
# GPIO Pad Configuration Bank

This block is the register file behind a bank of general-purpose pins. Software reaches it over a simple register bus. Each pin has two 32-bit configuration words placed eight bytes apart, starting at byte offset 0x100. Two shared bitmaps sit at the bottom of the map: a firmware-ownership map and an interrupt-routing map, each packed 32 pins to a word.

The bank turns the stored fields into pad controls for every pin:
- output value and output enable;
- weak pull-up and pull-down requests;
- a GPIO-versus-native select.

It also exports the trigger-type and polarity-invert fields to a separate edge/level detector. Pad input levels are brought in through a two-flop synchronizer. Software reads them back, gated by a per-pin input-sense disable.

When a pin is not in GPIO use, its pad output and output enable come straight from the native function's own signals.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin's first configuration word reads 0x0000_0004 (native use, input direction, output level 0). Every second word reads 0x0000_0004 (input sensing off, no pull). Every bitmap word reads 0.
- R2: A read whose rdEn is sampled at a rising edge presents its word on rdData from that edge on. rdData holds its value while rdEn is low.
- R3: The first configuration word of pin p is at byte 0x100+8*p. Its writable fields are:
  - bit 31: output level;
  - bit 4: trigger type, 1 = level;
  - bit 3: trigger invert;
  - bit 2: direction, 1 = input;
  - bits 1:0: use select, 1 = GPIO.
  All other bits read 0, apart from bit 30.
- R4: The second configuration word of pin p is at byte 0x104+8*p. Bit 2 set disables input sensing, and bits 1:0 hold the pull code. All other bits read 0.
- R5: Ownership bitmap word k is at byte 0x00+4*k and routing bitmap word k is at byte 0x10+4*k. Pin p is bit p%32 of word p/32. Bits for pins at or above the pin count read 0 and ignore writes.
- R6: Bit 30 of the first word ignores writes. It reads 0 while sensing is disabled. Otherwise it shows padIn[p] delayed by two flops, so a pad change driven before edge 1 is first returned by a read sampled at edge 3.
- R7: When use select is 1, padOut follows the output level and padOe is high exactly when direction is 0. For any other use select, padOut and padOe equal nativeOut and nativeOe.
- R8: Pull code 1 asserts pullDn, code 2 asserts pullUp, and codes 0 and 3 assert neither.
- R9: trigLevel and trigInv follow bits 4 and 3 of the pin's first word.
- R10: The following read 0 and change no state on write:
  - configuration addresses for pins at or beyond the pin count;
  - bitmap-region addresses outside the two maps;
  - addresses with nonzero bits 1:0.
- R11: gpioSel is high only when use select equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 32 | Registered read data |
| padIn | input | NUM_PINS | Raw pad input levels |
| nativeOut | input | NUM_PINS | Native-function output values |
| nativeOe | input | NUM_PINS | Native-function output enables |
| padOut | output | NUM_PINS | Value driven to each pad |
| padOe | output | NUM_PINS | Output enable of each pad |
| pullUp | output | NUM_PINS | Weak pull-up request |
| pullDn | output | NUM_PINS | Weak pull-down request |
| gpioSel | output | NUM_PINS | Pin is in GPIO use |
| trigLevel | output | NUM_PINS | Trigger type to the detector, 1 = level |
| trigInv | output | NUM_PINS | Trigger polarity invert to the detector |

## Verification
Several properties are checked on every cycle:
- pull-up and pull-down are never requested together for a pin;
- rdData never moves without a read;
- reads of addresses past the last pin return zero;
- a write selecting GPIO output direction turns on that pin's output enable on the next cycle;
- a write selecting any non-GPIO use drops gpioSel.

The bench scenarios cover the rest:
- every field of every pin read back;
- native pass-through;
- bitmap masking of the partial last word;
- the two-edge synchronizer latency;
- the sensing gate;
- writes to unmapped or misaligned addresses leaving their neighbours untouched.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int PIN_IDX_W  = 8;
  localparam int CFG_BASE   = 'h100;
  localparam int ROUTE_BASE = 'h10;

  // field positions in the first per-pin word
  localparam int A_OUT  = 31;
  localparam int A_IN   = 30;
  localparam int A_TRIG = 4;
  localparam int A_INV  = 3;
  localparam int A_DIR  = 2;
  // field position in the second per-pin word
  localparam int B_SENSE_OFF = 2;

  localparam logic [1:0] USE_GPIO  = 2'd1;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd2;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_OWN   = 3'd1,
    SEL_ROUTE = 3'd2,
    SEL_CFGA  = 3'd3,
    SEL_CFGB  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic                 wrStb;
    logic                 rdStb;
    regSel_e              sel;
    logic [1:0]           wordIdx;
    logic [PIN_IDX_W-1:0] pinIdx;
  } busStrobe_t;
endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output busStrobe_t        strobe
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int SLOT_W    = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CFG_BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [SLOT_W-1:0] SLOT_OFS   = SLOT_W'(CFG_BASE >> 3);
  localparam logic [SLOT_W-1:0] PIN_LIMIT  = SLOT_W'(NUM_PINS);
  localparam logic [2:0]        WORD_LIMIT = 3'(NUM_WORDS);

  logic [SLOT_W-1:0] cfgPin;
  logic              aligned;

  assign cfgPin  = addr[ADDR_W-1:3] - SLOT_OFS;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    strobe         = '0;
    strobe.sel     = SEL_NONE;
    strobe.wrStb   = wrEn;
    strobe.rdStb   = rdEn;
    strobe.wordIdx = addr[3:2];
    strobe.pinIdx  = cfgPin[PIN_IDX_W-1:0];
    if (aligned) begin
      if (addr >= CFG_BASE_A) begin
        if (cfgPin < PIN_LIMIT) begin
          strobe.sel = addr[2] ? SEL_CFGB : SEL_CFGA;
        end
      end else if (addr[ADDR_W-1:5] == '0) begin
        if ({1'b0, addr[3:2]} < WORD_LIMIT) begin
          strobe.sel = addr[4] ? SEL_ROUTE : SEL_OWN;
        end
      end
    end
  end
endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [31:0]         wrData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] nativeOut,
  input  logic [NUM_PINS-1:0] nativeOe,
  output logic [31:0]         rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] pullDn,
  output logic [NUM_PINS-1:0] gpioSel,
  output logic [NUM_PINS-1:0] trigLevel,
  output logic [NUM_PINS-1:0] trigInv
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  logic [31:0]         cfgAWord [NUM_PINS];
  logic [31:0]         cfgBWord [NUM_PINS];
  logic [NUM_PINS-1:0] ownV;
  logic [NUM_PINS-1:0] routeV;
  logic [PAD_W-1:0]    ownPad;
  logic [PAD_W-1:0]    routePad;
  logic [31:0]         rdWord;
  wire                 unusedWr = ^wrData[29:5];

  wire wrA     = strobe.wrStb && (strobe.sel == SEL_CFGA);
  wire wrB     = strobe.wrStb && (strobe.sel == SEL_CFGB);
  wire wrOwn   = strobe.wrStb && (strobe.sel == SEL_OWN);
  wire wrRoute = strobe.wrStb && (strobe.sel == SEL_ROUTE);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0]           WORD_OF = 2'(p / 32);
    localparam int                   BIT_OF  = p % 32;
    localparam logic [PIN_IDX_W-1:0] ME      = PIN_IDX_W'(p);

    logic       outLvl, trigSel, invSel, dirIn, senseOff, ownR, routeR;
    logic       syncA, syncB, inLvl, isGpio;
    logic [1:0] useSel, pullSel;
    wire        hitPin = (strobe.pinIdx == ME);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outLvl   <= 1'b0;
        trigSel  <= 1'b0;
        invSel   <= 1'b0;
        dirIn    <= 1'b1;
        useSel   <= 2'd0;
        senseOff <= 1'b1;
        pullSel  <= 2'd0;
        ownR     <= 1'b0;
        routeR   <= 1'b0;
        syncA    <= 1'b0;
        syncB    <= 1'b0;
      end else begin
        syncA <= padIn[p];
        syncB <= syncA;
        if (wrA && hitPin) begin
          outLvl  <= wrData[A_OUT];
          trigSel <= wrData[A_TRIG];
          invSel  <= wrData[A_INV];
          dirIn   <= wrData[A_DIR];
          useSel  <= wrData[1:0];
        end
        if (wrB && hitPin) begin
          senseOff <= wrData[B_SENSE_OFF];
          pullSel  <= wrData[1:0];
        end
        if (wrOwn && (strobe.wordIdx == WORD_OF)) begin
          ownR <= wrData[BIT_OF];
        end
        if (wrRoute && (strobe.wordIdx == WORD_OF)) begin
          routeR <= wrData[BIT_OF];
        end
      end
    end

    assign inLvl  = syncB & ~senseOff;
    assign isGpio = (useSel == USE_GPIO);

    assign cfgAWord[p] = {outLvl, inLvl, 25'd0, trigSel, invSel, dirIn, useSel};
    assign cfgBWord[p] = {29'd0, senseOff, pullSel};
    assign ownV[p]     = ownR;
    assign routeV[p]   = routeR;

    assign padOut[p]    = isGpio ? outLvl : nativeOut[p];
    assign padOe[p]     = isGpio ? ~dirIn : nativeOe[p];
    assign pullUp[p]    = (pullSel == PULL_UP);
    assign pullDn[p]    = (pullSel == PULL_DOWN);
    assign gpioSel[p]   = isGpio;
    assign trigLevel[p] = trigSel;
    assign trigInv[p]   = invSel;
  end

  assign ownPad   = PAD_W'(ownV);
  assign routePad = PAD_W'(routeV);

  always_comb begin
    rdWord = '0;
    unique case (strobe.sel)
      SEL_CFGA: begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (strobe.pinIdx == PIN_IDX_W'(p)) rdWord = cfgAWord[p];
        end
      end
      SEL_CFGB: begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (strobe.pinIdx == PIN_IDX_W'(p)) rdWord = cfgBWord[p];
        end
      end
      SEL_OWN: begin
        for (int k = 0; k < NUM_WORDS; k++) begin
          if (strobe.wordIdx == 2'(k)) rdWord = ownPad[k*32 +: 32];
        end
      end
      SEL_ROUTE: begin
        for (int k = 0; k < NUM_WORDS; k++) begin
          if (strobe.wordIdx == 2'(k)) rdWord = routePad[k*32 +: 32];
        end
      end
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdStb) begin
      rdData <= rdWord;
    end
  end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  input  logic                rdEn,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] nativeOut,
  input  logic [NUM_PINS-1:0] nativeOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] pullDn,
  output logic [NUM_PINS-1:0] gpioSel,
  output logic [NUM_PINS-1:0] trigLevel,
  output logic [NUM_PINS-1:0] trigInv
);
  busStrobe_t strobe;

  gpb_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  gpb_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .padIn     (padIn),
    .nativeOut (nativeOut),
    .nativeOe  (nativeOe),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .pullUp    (pullUp),
    .pullDn    (pullDn),
    .gpioSel   (gpioSel),
    .trigLevel (trigLevel),
    .trigInv   (trigInv)
  );
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic [2:0]          wrMode,
  input logic                rdEn,
  input logic [31:0]         rdData,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] gpioSel,
  input logic [NUM_PINS-1:0] pullUp,
  input logic [NUM_PINS-1:0] pullDn
);
  localparam logic [ADDR_W-1:0] END_A = ADDR_W'(CFG_BASE + 8 * NUM_PINS);

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDn) == '0); // R8

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R2

  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr >= END_A) |=> rdData == 32'd0); // R10

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    localparam logic [ADDR_W-3:0] SLOT = (ADDR_W-2)'((CFG_BASE + 8 * p) >> 2);

    AST_GPIO_OUT_OE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr[ADDR_W-1:2] == SLOT && addr[1:0] == 2'b00 &&
       wrMode[1:0] == USE_GPIO && !wrMode[2]) |=> padOe[p]); // R7

    AST_NATIVE_DROPS_SEL: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr[ADDR_W-1:2] == SLOT && addr[1:0] == 2'b00 &&
       wrMode[1:0] != USE_GPIO) |=> !gpioSel[p]); // R11
  end
endmodule

bind gpio_pad_bank gpb_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .wrMode  (wrData[2:0]),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .padOe   (padOe),
  .gpioSel (gpioSel),
  .pullUp  (pullUp),
  .pullDn  (pullDn)
);

// File: tb/gpio_pad_bank_test.sv
module gpio_pad_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic [TP-1:0] padIn = '0;
  logic [TP-1:0] nativeOut = {5{8'hC3}};
  logic [TP-1:0] nativeOe  = {5{8'h5A}};
  logic [TP-1:0] padOut, padOe, pullUp, pullDn, gpioSel, trigLevel, trigInv;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_bank #(.NUM_PINS(TP), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .padIn(padIn), .nativeOut(nativeOut),
    .nativeOe(nativeOe), .padOut(padOut), .padOe(padOe), .pullUp(pullUp),
    .pullDn(pullDn), .gpioSel(gpioSel), .trigLevel(trigLevel), .trigInv(trigInv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [AW-1:0] cfgA(input int p);
    return AW'(32'h100 + 8 * p);
  endfunction

  function automatic logic [31:0] patA(input int p);
    logic [5:0] pb;
    pb = 6'(p);
    return {pb[5], 1'b1, 25'h1FF_FFFF, pb[4:0]};
  endfunction

  initial begin
    logic [31:0] r;
    logic [31:0] expW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int p = 0; p < TP; p++) begin
      busRead(cfgA(p), r);     check("R1 cfgA reset", r, 32'h4);
      busRead(cfgA(p) + 4, r); check("R1 cfgB reset", r, 32'h4);
    end
    for (int k = 0; k < 8; k++) begin
      busRead(AW'(4 * k), r); check("R1 bitmap reset", r, 32'h0);
    end
    check("R1 padOe native", {8'd0, padOe}, {8'd0, nativeOe});

    // R3 R6 R7 R9 R11 first word sweep
    for (int p = 0; p < TP; p++) busWrite(cfgA(p), patA(p));
    for (int p = 0; p < TP; p++) begin
      logic [5:0] pb;
      logic isG;
      pb = 6'(p);
      isG = (pb[1:0] == 2'd1);
      busRead(cfgA(p), r);
      check("R3 cfgA readback (R6 bit30 ignores write)", r, patA(p) & 32'h8000_001F);
      check("R11 gpioSel", {31'd0, gpioSel[p]}, {31'd0, isG});
      check("R7 padOe", {31'd0, padOe[p]}, {31'd0, isG ? ~pb[2] : nativeOe[p]});
      check("R7 padOut", {31'd0, padOut[p]}, {31'd0, isG ? pb[5] : nativeOut[p]});
      check("R9 trigLevel", {31'd0, trigLevel[p]}, {31'd0, pb[4]});
      check("R9 trigInv", {31'd0, trigInv[p]}, {31'd0, pb[3]});
    end

    // R4 R8 second word sweep
    for (int p = 0; p < TP; p++) busWrite(cfgA(p) + 4, 32'hFFFF_FFF8 | 32'(p % 8));
    for (int p = 0; p < TP; p++) begin
      logic [1:0] pc;
      pc = 2'(p % 4);
      busRead(cfgA(p) + 4, r);
      check("R4 cfgB readback", r, 32'(p % 8));
      check("R8 pullUp", {31'd0, pullUp[p]}, {31'd0, pc == 2'd2});
      check("R8 pullDn", {31'd0, pullDn[p]}, {31'd0, pc == 2'd1});
    end

    // R6 sensing enabled, sampled levels
    padIn = {5{8'h96}};
    for (int p = 0; p < TP; p++) busWrite(cfgA(p) + 4, 32'h0);
    for (int p = 0; p < TP; p++) begin
      busRead(cfgA(p), r);
      expW = (patA(p) & 32'h8000_001F) | (32'(padIn[p]) << 30);
      check("R6 sensed level", r, expW);
    end

    // R6 two-flop latency on pin 3
    padIn[3] = 1'b1;
    expW = patA(3) & 32'h8000_001F;
    busRead(cfgA(3), r); check("R6 latency edge1", r, expW);
    busRead(cfgA(3), r); check("R6 latency edge2", r, expW);
    busRead(cfgA(3), r); check("R6 latency edge3", r, expW | 32'h4000_0000);
    busWrite(cfgA(3) + 4, 32'h4);
    busRead(cfgA(3), r); check("R6 sense off reads 0", r, expW);

    // R5 bitmaps with partial last word
    for (int k = 0; k < 4; k++) busWrite(AW'(4 * k), 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) busWrite(AW'(32'h10 + 4 * k), 32'hA5A5_A5A5);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] m;
      m = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0000_00FF : 32'h0;
      busRead(AW'(4 * k), r);          check("R5 ownership word", r, m);
      busRead(AW'(32'h10 + 4 * k), r); check("R5 routing word", r, m & 32'hA5A5_A5A5);
    end
    busWrite(AW'(4), 32'h0000_0001);
    busRead(AW'(4), r); check("R5 ownership pin 32 only", r, 32'h1);

    // R10 unmapped, out of range, misaligned
    busWrite(cfgA(TP), 32'hFFFF_FFFF);
    busRead(cfgA(TP), r);     check("R10 pin beyond count", r, 32'h0);
    busRead(cfgA(TP) + 4, r); check("R10 pin beyond count word2", r, 32'h0);
    busRead(cfgA(TP - 1), r);
    check("R10 last pin untouched", r, (patA(TP - 1) & 32'h8000_001F) | (32'(padIn[TP-1]) << 30));
    busWrite(AW'(32'h20), 32'hFFFF_FFFF);
    busRead(AW'(32'h20), r);  check("R10 gap region", r, 32'h0);
    busWrite(cfgA(2) + 1, 32'h0);
    busRead(cfgA(2) + 1, r);  check("R10 misaligned read", r, 32'h0);
    busRead(cfgA(2), r);
    check("R10 misaligned write ignored", r, (patA(2) & 32'h8000_001F) | (32'(padIn[2]) << 30));

    // R2 hold without read
    busRead(AW'(0), r);
    repeat (3) @(negedge clk);
    check("R2 rdData holds", rdData, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule